// File: doc/BRIEF.md
# Reset and Watchdog Controller

This block gathers every source of reset for a small USB peripheral controller and turns them into two outputs: one that holds the embedded CPU in reset and one that clears the USB interface logic. It has three sources. The first is an external reset pin, which is synchronised and must stay high for a set number of machine cycles before it counts. The second is a software warm reset, started by a register write. The third is a free-running watchdog that firmware keeps quiet by writing a key value.

A write port lets firmware reach the few control bits the block needs. One register holds the device address and the bit that asks for the upstream pull-up. One register starts a warm reset. One register chooses whether a warm reset also reaches the CPU, and whether the pull-up stays on while any reset is active. The last register is the watchdog key. Any reset forces the device address to zero.

Timing is counted in oscillator clocks. A machine cycle is `CLKS_PER_MC` clocks. The pin qualification time, the watchdog period and the length of the generated pulse are all whole numbers of machine cycles.

Top module: `reset_wdt_ctrl`

## Requirements
- R1: The external reset takes effect only when `ext_rst_pin` has been sampled high on `QUAL_MC*CLKS_PER_MC` consecutive clock edges. A single low sample restarts the count, so shorter or broken pulses assert neither reset output.
- R2: Once qualified, the external reset holds `cpu_rst` and `usb_rst` high for as long as the pin stays high. Both drop three clock edges after the first edge that samples the pin low.
- R3: With no key write, the watchdog expires `WDT_MC*CLKS_PER_MC` clocks after its last restart. Expiry drives `cpu_rst` and `usb_rst` high for exactly `PULSE_MC*CLKS_PER_MC` clocks.
- R4: Writing the byte AAh to address 0Eh restarts the watchdog count from zero. Any other byte written to 0Eh, and AAh written to any other address, leave the count running.
- R5: Writing to address 05h with bit 4 set starts a warm reset. It drives `usb_rst` high from the next clock for exactly `PULSE_MC*CLKS_PER_MC` clocks. A write to 05h with bit 4 clear has no effect.
- R6: A warm reset drives `cpu_rst` only if bit 1 of address 09h was set when the warm reset started. `cpu_rst` is never high without `usb_rst`.
- R7: `bus_pullup` follows bit 7 of address 03h. While `usb_rst` is high, it is forced low unless bit 0 of address 09h is set.
- R8: Bits 6:0 of a write to address 03h load `dev_addr`. From one clock after any reset becomes active, `dev_addr` reads zero, and address writes made during the reset are dropped.
- R9: After `por_n` is released, the outputs are in their idle state: both resets low, `bus_pullup` low and `dev_addr` zero.
- R10: The watchdog count is held at zero while `usb_rst` is high. It starts counting again only after the reset ends, so the next expiry comes a full period after the reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of the block, active low, asynchronous |
| ext_rst_pin | input | 1 | External reset pin, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_rst | output | 1 | CPU reset, active high |
| usb_rst | output | 1 | USB logic reset, active high |
| bus_pullup | output | 1 | Upstream pull-up enable |
| dev_addr | output | 7 | Current USB device address |

## Verification
The bench builds the block with `CLKS_PER_MC=4`, `QUAL_MC=2`, `WDT_MC=100` and `PULSE_MC=3`. This gives an 8-clock qualification window, a 400-clock watchdog period and a 12-clock reset pulse. With these short windows, the bench can check the exact edge on which the watchdog fires, after a restart and after a reset ends. It can check the exact edge on which a pin pulse qualifies or is rejected, and the first and last clock of every generated pulse, all within a few thousand cycles.

// File: rtl/reset_wdt_pkg.sv
package reset_wdt_pkg;

    // register addresses seen on the write port
    localparam logic [7:0] ADDR_LINK   = 8'h03;
    localparam logic [7:0] ADDR_EVENT  = 8'h05;
    localparam logic [7:0] ADDR_RSTCFG = 8'h09;
    localparam logic [7:0] ADDR_WDOG   = 8'h0E;

    localparam logic [7:0] WDOG_KEY = 8'hAA;

    // bit positions inside those registers
    localparam int LINK_BIT    = 7;
    localparam int WARM_BIT    = 4;
    localparam int CPU_SEL_BIT = 1;
    localparam int KEEP_BIT    = 0;

    // sources that produce a timed reset pulse
    localparam int SRC_WDOG      = 0;
    localparam int SRC_WARM      = 1;
    localparam int NUM_PULSE_SRC = 2;

    typedef struct packed {
        logic [6:0] addr;
        logic       link;
        logic       cpu_sel;
        logic       keep;
        logic       warm_cpu;
    } ctrl_regs_t;

endpackage

// File: rtl/rw_pin_filter.sv
module rw_pin_filter #(
    parameter int QUAL_CLKS = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin,
    output logic hold
);
    localparam int CW = $clog2(QUAL_CLKS);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          hold;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        if (!st_q.s2) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b0;
        end else if (!st_q.hold) begin
            if (st_q.cnt == LAST) st_d.hold = 1'b1;
            else                  st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold = st_q.hold;
endmodule

// File: rtl/rw_watchdog.sv
module rw_watchdog #(
    parameter int LIMIT_CLKS = 786432
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic pause,
    output logic expire
);
    localparam int CW = $clog2(LIMIT_CLKS);
    localparam logic [CW-1:0] LAST = CW'(LIMIT_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wdog_t;

    wdog_t st_d, st_q;

    assign expire = !pause && !clear && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (pause || clear || expire) st_d.cnt = '0;
        else                          st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rw_pulse.sv
module rw_pulse #(
    parameter int LEN_CLKS = 288
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN_CLKS + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)                st_d.left = CW'(LEN_CLKS);
        else if (st_q.left != '0) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.left != '0);
endmodule

// File: rtl/reset_wdt_ctrl.sv
module reset_wdt_ctrl
    import reset_wdt_pkg::*;
#(
    parameter int CLKS_PER_MC = 12,
    parameter int QUAL_MC     = 2,
    parameter int WDT_MC      = 65536,
    parameter int PULSE_MC    = 24
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_pin,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       cpu_rst,
    output logic       usb_rst,
    output logic       bus_pullup,
    output logic [6:0] dev_addr
);
    localparam int QUAL_CLKS  = QUAL_MC * CLKS_PER_MC;
    localparam int WDT_CLKS   = WDT_MC * CLKS_PER_MC;
    localparam int PULSE_CLKS = PULSE_MC * CLKS_PER_MC;

    logic                     ext_hold;
    logic                     wdt_expire;
    logic                     any_rst;
    logic                     key_hit, warm_hit, link_wr, cfg_wr;
    logic [NUM_PULSE_SRC-1:0] pulse_start;
    logic [NUM_PULSE_SRC-1:0] pulse_act;
    ctrl_regs_t               r_d, r_q;

    // write decode
    assign key_hit  = wr_en && (wr_addr == ADDR_WDOG) && (wr_data == WDOG_KEY);
    assign warm_hit = wr_en && (wr_addr == ADDR_EVENT) && wr_data[WARM_BIT];
    assign link_wr  = wr_en && (wr_addr == ADDR_LINK);
    assign cfg_wr   = wr_en && (wr_addr == ADDR_RSTCFG);

    rw_pin_filter #(.QUAL_CLKS(QUAL_CLKS)) u_filt (
        .clk   (clk),
        .por_n (por_n),
        .pin   (ext_rst_pin),
        .hold  (ext_hold)
    );

    rw_watchdog #(.LIMIT_CLKS(WDT_CLKS)) u_wdt (
        .clk    (clk),
        .por_n  (por_n),
        .clear  (key_hit),
        .pause  (any_rst),
        .expire (wdt_expire)
    );

    always_comb begin
        pulse_start           = '0;
        pulse_start[SRC_WDOG] = wdt_expire;
        pulse_start[SRC_WARM] = warm_hit;
    end

    for (genvar g = 0; g < NUM_PULSE_SRC; g++) begin : g_pulse
        rw_pulse #(.LEN_CLKS(PULSE_CLKS)) u_pulse (
            .clk    (clk),
            .por_n  (por_n),
            .start  (pulse_start[g]),
            .active (pulse_act[g])
        );
    end

    assign any_rst = ext_hold | pulse_act[SRC_WDOG] | pulse_act[SRC_WARM];

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            r_d.cpu_sel = wr_data[CPU_SEL_BIT];
            r_d.keep    = wr_data[KEEP_BIT];
        end
        if (link_wr) begin
            r_d.link = wr_data[LINK_BIT];
            if (!any_rst) r_d.addr = wr_data[6:0];
        end
        if (any_rst)  r_d.addr     = '0;
        if (warm_hit) r_d.warm_cpu = r_q.cpu_sel;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign usb_rst    = any_rst;
    assign cpu_rst    = ext_hold | pulse_act[SRC_WDOG]
                      | (pulse_act[SRC_WARM] & r_q.warm_cpu);
    assign bus_pullup = r_q.link & ~(any_rst & ~r_q.keep);
    assign dev_addr   = r_q.addr;
endmodule

// File: rtl/reset_wdt_ctrl_chk.sv
module reset_wdt_ctrl_chk
    import reset_wdt_pkg::*;
(
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_pin,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       cpu_rst,
    input logic       usb_rst,
    input logic [6:0] dev_addr,
    input logic       ext_hold,
    input logic       wdt_expire
);
    logic key_wr, warm_wr;
    assign key_wr  = wr_en && (wr_addr == ADDR_WDOG) && (wr_data == WDOG_KEY);
    assign warm_wr = wr_en && (wr_addr == ADDR_EVENT) && wr_data[WARM_BIT];

    // R8: address is zero one clock into any reset
    p_addr_zero_r8: assert property (@(posedge clk) disable iff (!por_n)
        usb_rst |=> (dev_addr == 7'd0));

    // R6: CPU reset never without USB reset
    p_cpu_needs_usb_r6: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst |-> usb_rst);

    // R5: a warm trigger write raises the USB reset next clock
    p_warm_start_r5: assert property (@(posedge clk) disable iff (!por_n)
        warm_wr |=> usb_rst);

    // R2: four low samples of the pin end the external reset
    p_ext_release_r2: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_rst_pin && !$past(ext_rst_pin) && !$past(ext_rst_pin, 2)
         && !$past(ext_rst_pin, 3)) |-> !ext_hold);

    // R3: an expiry produces both resets on the next clock
    p_expire_start_r3: assert property (@(posedge clk) disable iff (!por_n)
        wdt_expire |=> (usb_rst && cpu_rst));

    // R4: a key write cannot be followed at once by an expiry
    p_key_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        key_wr |=> !wdt_expire);
endmodule

bind reset_wdt_ctrl reset_wdt_ctrl_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .ext_rst_pin (ext_rst_pin),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cpu_rst     (cpu_rst),
    .usb_rst     (usb_rst),
    .dev_addr    (dev_addr),
    .ext_hold    (ext_hold),
    .wdt_expire  (wdt_expire)
);

// File: tb/reset_wdt_ctrl_tb.sv
`timescale 1ns/1ps
module reset_wdt_ctrl_tb;
    localparam int CPM  = 4;
    localparam int QMC  = 2;
    localparam int WMC  = 100;
    localparam int PMC  = 3;
    localparam int QUAL = QMC * CPM;
    localparam int LIM  = WMC * CPM;
    localparam int P    = PMC * CPM;

    localparam logic [3:0] M_CPU = 4'b0001, M_USB = 4'b0010,
                           M_PULL = 4'b0100, M_ADDR = 4'b1000;

    logic       clk = 1'b0;
    logic       por_n, pin, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic       cpu_rst, usb_rst, bus_pullup;
    logic [6:0] dev_addr;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int last_wr = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [3:0] mask;
        logic       cpu, usb, pull;
        logic [6:0] addr;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reset_wdt_ctrl #(.CLKS_PER_MC(CPM), .QUAL_MC(QMC), .WDT_MC(WMC),
                     .PULSE_MC(PMC)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_pin(pin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cpu_rst(cpu_rst),
        .usb_rst(usb_rst), .bus_pullup(bus_pullup), .dev_addr(dev_addr)
    );

    // driver side: push an expectation for the current negedge
    task automatic push_exp(input string tag, input logic [3:0] mask,
                            input logic c, input logic u, input logic p,
                            input logic [6:0] a);
        exp_t e;
        e.tag = tag; e.mask = mask; e.cpu = c; e.usb = u; e.pull = p; e.addr = a;
        sbq.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 last_wr = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: compare queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                bit bad;
                e = sbq.pop_front();
                bad = 0;
                if (e.mask[0] && cpu_rst    !== e.cpu)  bad = 1;
                if (e.mask[1] && usb_rst    !== e.usb)  bad = 1;
                if (e.mask[2] && bus_pullup !== e.pull) bad = 1;
                if (e.mask[3] && dev_addr   !== e.addr) bad = 1;
                n_cmp++;
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: got cpu=%0b usb=%0b pull=%0b addr=%h, expected cpu=%0b usb=%0b pull=%0b addr=%h (mask %b)",
                             e.tag, cpu_rst, usb_rst, bus_pullup, dev_addr,
                             e.cpu, e.usb, e.pull, e.addr, e.mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, w, w2, w3;
        por_n = 1'b0; pin = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        push_exp("R9 idle after power-up", 4'hF, 0, 0, 0, 7'h00);

        wr(8'h0E, 8'hAA);
        wr(8'h03, 8'hAA);
        push_exp("R7 R8 link and address load", 4'hF, 0, 0, 1, 7'h2A);

        // R1: pulse one sample short
        @(negedge clk); pin = 1'b1; t0 = cyc;
        wait_to(t0 + QUAL - 1); pin = 1'b0;
        wait_to(t0 + QUAL + 4);
        push_exp("R1 short pulse ignored", M_CPU | M_USB, 0, 0, 0, 0);

        // R1: two short bursts split by one low sample
        @(negedge clk); pin = 1'b1; t0 = cyc;
        wait_to(t0 + QUAL - 1); pin = 1'b0;
        @(negedge clk); pin = 1'b1; t0 = cyc;
        wait_to(t0 + QUAL - 1); pin = 1'b0;
        wait_to(t0 + QUAL + 4);
        push_exp("R1 count restarts on low", M_CPU | M_USB, 0, 0, 0, 0);

        // R1/R2: qualifying pulse held long
        @(negedge clk); pin = 1'b1; t0 = cyc;
        wait_to(t0 + QUAL + 1);
        push_exp("R1 not yet qualified", M_USB, 0, 0, 0, 0);
        wait_to(t0 + QUAL + 2);
        push_exp("R1 R7 qualified reset drops pull-up", M_CPU | M_USB | M_PULL, 1, 1, 0, 0);
        wait_to(t0 + QUAL + 3);
        push_exp("R8 address cleared by external reset", M_ADDR, 0, 0, 0, 7'h00);
        wait_to(t0 + 40);
        push_exp("R2 reset held while pin high", M_CPU | M_USB, 1, 1, 0, 0);
        pin = 1'b0; t1 = cyc;
        wait_to(t1 + 2);
        push_exp("R2 still held two edges after release", M_USB, 0, 1, 0, 0);
        wait_to(t1 + 3);
        push_exp("R2 released", 4'hF, 0, 0, 1, 7'h00);

        // R3/R10: watchdog expiry and restart after reset
        wr(8'h0E, 8'hAA); w = last_wr;
        wait_to(w + LIM - 1);
        push_exp("R3 no expiry before period", M_CPU | M_USB, 0, 0, 0, 0);
        wait_to(w + LIM);
        push_exp("R3 expiry asserts both resets", M_CPU | M_USB, 1, 1, 0, 0);
        wait_to(w + LIM + P - 1);
        push_exp("R3 pulse last clock", M_CPU | M_USB, 1, 1, 0, 0);
        wait_to(w + LIM + P);
        push_exp("R3 pulse ended", M_CPU | M_USB, 0, 0, 0, 0);
        wait_to(w + LIM + P + LIM - 1);
        push_exp("R10 count held during reset", M_USB, 0, 0, 0, 0);
        wait_to(w + LIM + P + LIM);
        push_exp("R10 next expiry one period after reset", M_USB, 0, 1, 0, 0);
        wait_to(w + LIM + P + LIM + P);

        // R4: wrong keys do not restart
        wr(8'h0E, 8'hAA); w = last_wr;
        wait_to(w + 100);
        wr(8'h0E, 8'h55);
        wr(8'h0D, 8'hAA);
        wr(8'h0E, 8'hAB);
        wait_to(w + LIM - 1);
        push_exp("R4 bad keys, no early expiry", M_USB, 0, 0, 0, 0);
        wait_to(w + LIM);
        push_exp("R4 bad keys ignored, expiry on time", M_USB, 0, 1, 0, 0);
        wait_to(w + LIM + P);
        wr(8'h0E, 8'hAA); w2 = last_wr;
        wait_to(w2 + 300);
        wr(8'h0E, 8'hAA); w3 = last_wr;
        wait_to(w2 + LIM);
        push_exp("R4 good key defers expiry", M_USB, 0, 0, 0, 0);
        wait_to(w3 + LIM - 1);
        push_exp("R4 deferred expiry not early", M_USB, 0, 0, 0, 0);
        wait_to(w3 + LIM);
        push_exp("R4 deferred expiry on time", M_USB, 0, 1, 0, 0);
        wait_to(w3 + LIM + P);
        wr(8'h0E, 8'hAA);

        // R5/R6/R7: warm reset, CPU spared, pull-up kept
        wr(8'h09, 8'h01);
        wr(8'h03, 8'hAA);
        wr(8'h05, 8'h10); w = last_wr;
        push_exp("R5 R6 R7 warm without CPU, pull-up kept", M_CPU | M_USB | M_PULL, 0, 1, 1, 0);
        wait_to(w + 1);
        push_exp("R8 address cleared by warm reset", M_ADDR, 0, 0, 0, 7'h00);
        wait_to(w + P - 1);
        push_exp("R5 warm pulse last clock", M_USB, 0, 1, 0, 0);
        wait_to(w + P);
        push_exp("R5 warm pulse ended", 4'hF, 0, 0, 1, 7'h00);
        wr(8'h05, 8'hEF); w = last_wr;
        wait_to(w + 1);
        push_exp("R5 bit 4 clear has no effect", M_USB | M_CPU, 0, 0, 0, 0);
        wait_to(w + 6);
        push_exp("R5 still idle", M_USB, 0, 0, 0, 0);

        // R6/R7/R8: warm reset reaching the CPU, pull-up dropped
        wr(8'h09, 8'h02);
        wr(8'h03, 8'h95);
        push_exp("R8 address 15h loaded", M_ADDR | M_PULL, 0, 0, 1, 7'h15);
        wr(8'h05, 8'h10); w = last_wr;
        push_exp("R6 R7 warm with CPU, pull-up dropped", M_CPU | M_USB | M_PULL, 1, 1, 0, 0);
        wr(8'h03, 8'hB3);
        wait_to(w + P);
        push_exp("R8 address write during reset dropped", 4'hF, 0, 0, 1, 7'h00);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule